// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management interface of an Ethernet PHY. Software starts a transfer by writing one 32-bit command word. The word holds the PHY address, the register address, the write data and a start bit for a read or for a write. The hardware then sends the whole management frame bit by bit on the management clock and data pins.

The data pin is bidirectional. The block drives it through a separate output and an output-enable, and takes the returned value on a separate input. A status word can be read at any time. It shows a busy flag, a read-complete flag and the last 16 bits read.

A separate scan request makes the block read the identifier register of every PHY address in ascending order. It stops at the first address that answers with a usable value. If no address answers, it reports a default address together with a not-found flag.

Top module: `mdio_cmd_master`

## Requirements
- R1: A command write starts a frame only if command bit 27 (read) or bit 26 (write) is set. If both bits are set, a read is performed. Bits 25:21 give the PHY address, bits 20:16 give the register address and bits 15:0 give the write data. A write with neither start bit set starts nothing.
- R2: Every frame opens with exactly 35 driven 1 bits on the data pin, followed by the start pattern 0 then 1.
- R3: After the start pattern come the opcode bits and then the address bits. The opcode is 0,1 for a write and 1,0 for a read. The 5-bit PHY address follows, then the 5-bit register address, each sent most significant bit first.
- R4: A write frame then drives the turnaround bits 1,0 and the 16 data bits, most significant bit first. The output-enable stays high for the whole write frame.
- R5: A read frame drops the output-enable for one turnaround bit time and keeps it low to the end of the frame. The 16 returned bits are sampled most significant bit first while the clock pin is high. At the end of the frame, status bits 15:0 hold the returned data and status bit 28 reads 1.
- R6: Status bit 31 reads 1 from the cycle after a command or scan is accepted until its last frame ends. Status bit 28 is cleared when a new command is accepted. After reset the whole status word is zero.
- R7: A command write or scan request that arrives while the block is busy is ignored. It produces no frame and leaves the status word unchanged.
- R8: Each clock-pin period is 2*HALF_DIV system clocks, with HALF_DIV clocks high and HALF_DIV low. With a 50 MHz system clock the default HALF_DIV of 10 gives 2.5 MHz. While idle, the clock pin and the output-enable are low.
- R9: The data output changes only in cycles where the clock pin is low.
- R10: A scan reads register 3 at PHY addresses 0, 1, 2 and so on, in that order. It stops at the first address whose value is neither 0x0000 nor 0xFFFF. That address appears on scanAddr, scanMiss is 0 and scanValid is 1.
- R11: If none of the 32 addresses qualifies, the scan ends after 32 frames with scanAddr equal to 1, scanMiss equal to 1 and scanValid equal to 1.
- R12: Scan frames do not change status bits 28 and 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 32 | Command word |
| scanStart | input | 1 | One-cycle request to scan all PHY addresses |
| mdioIn | input | 1 | Data pin value as seen from the pad |
| mdc | output | 1 | Management clock pin |
| mdioOut | output | 1 | Data pin output value |
| mdioOe | output | 1 | Data pin output enable |
| regRd | output | 32 | Status word: busy (31), read done (28), read data (15:0) |
| scanAddr | output | 5 | Address reported by the last scan |
| scanMiss | output | 1 | Last scan found no answering PHY |
| scanValid | output | 1 | Scan result is valid |

## Verification
The bench models a PHY that decodes each frame from the pins and answers reads with a value derived from the addresses. A scoreboard compares every decoded frame with the command that caused it.

- A command arriving mid-frame would show up as an extra, unexpected frame.
- A word with both start bits set that is handled as a write would show the wrong opcode.
- An off-by-one in the turnaround handling would shift the returned data by one bit.
- Two scans cover the stop condition. The first finds its PHY after several addresses that answer with both 0x0000 and 0xFFFF. The second finds nothing, which exposes a scan that stops early, skips address 31 or forgets the default address.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 35;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int RD_FIRST  = TA_IDX + 1;
  localparam int RD_LAST   = TA_IDX + 16;
  localparam int WR_LAST   = TA_IDX + 17;
  localparam int ID_REG    = 3;

  localparam int CMD_RD_BIT = 27;
  localparam int CMD_WR_BIT = 26;
  localparam int STS_BUSY   = 31;
  localparam int STS_DONE   = 28;

  typedef struct packed {
    logic        load;
    logic        shift;
    logic        sample;
    logic        finish;
    logic        isRead;
    logic        isScan;
    logic [4:0]  phy;
    logic [4:0]  regAd;
    logic [15:0] wdata;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic        cmdRd,
  input  logic        cmdWr,
  input  logic [4:0]  cmdPhy,
  input  logic [4:0]  cmdReg,
  input  logic [15:0] cmdData,
  input  logic        scanStart,
  input  logic        answerValid,
  output mdioStrobe_t stb,
  output logic        busy,
  output logic        mdc,
  output logic        mdioOe
);
  localparam int PHASE_MAX = 2 * HALF_DIV - 1;
  localparam int PH_W      = $clog2(2 * HALF_DIV);
  localparam int BIT_W     = $clog2(FRAME_LEN);

  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;
  logic             isRead, isScan;
  logic [4:0]       phy, regAd;
  logic [15:0]      wdata;

  logic cmdHit, accept, bitEnd, lastBit, finish, nextScan, load;
  logic nRead, nScan;
  logic [4:0] nPhy, nReg;
  logic [15:0] nData;

  assign cmdHit   = cmdWrEn && (cmdRd || cmdWr);
  assign accept   = !busy && (cmdHit || scanStart);
  assign bitEnd   = busy && (phase == PH_W'(PHASE_MAX));
  assign lastBit  = isRead ? (bitCnt == BIT_W'(RD_LAST)) : (bitCnt == BIT_W'(WR_LAST));
  assign finish   = bitEnd && lastBit;
  assign nextScan = finish && isScan && !answerValid && (phy != 5'd31);
  assign load     = accept || nextScan;

  always_comb begin
    nRead = isRead;
    nScan = isScan;
    nPhy  = phy;
    nReg  = regAd;
    nData = wdata;
    if (accept) begin
      if (cmdHit) begin
        nRead = cmdRd;
        nScan = 1'b0;
        nPhy  = cmdPhy;
        nReg  = cmdReg;
        nData = cmdData;
      end else begin
        nRead = 1'b1;
        nScan = 1'b1;
        nPhy  = 5'd0;
        nReg  = 5'(ID_REG);
        nData = 16'h0000;
      end
    end else if (nextScan) begin
      nPhy = phy + 5'd1;
    end
  end

  always_comb begin
    stb.load   = load;
    stb.shift  = bitEnd && !lastBit;
    stb.sample = bitEnd && isRead && (bitCnt >= BIT_W'(RD_FIRST));
    stb.finish = finish;
    stb.isRead = nRead;
    stb.isScan = nScan;
    stb.phy    = nPhy;
    stb.regAd  = nReg;
    stb.wdata  = nData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
      isRead <= 1'b0;
      isScan <= 1'b0;
      phy    <= '0;
      regAd  <= '0;
      wdata  <= '0;
    end else begin
      if (load) begin
        busy   <= 1'b1;
        phase  <= '0;
        bitCnt <= '0;
        isRead <= nRead;
        isScan <= nScan;
        phy    <= nPhy;
        regAd  <= nReg;
        wdata  <= nData;
      end else if (busy) begin
        if (finish) begin
          busy  <= 1'b0;
          phase <= '0;
        end else if (bitEnd) begin
          phase  <= '0;
          bitCnt <= bitCnt + BIT_W'(1);
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

  assign mdc    = busy && (phase >= PH_W'(HALF_DIV));
  assign mdioOe = busy && !(isRead && (bitCnt >= BIT_W'(TA_IDX)));
endmodule

// File: rtl/mdio_data.sv
module mdio_data
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t stb,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        answerValid,
  output logic        rdDone,
  output logic [15:0] rdData,
  output logic [4:0]  scanAddr,
  output logic        scanMiss,
  output logic        scanValid
);
  logic [FRAME_LEN-1:0] frameSr;
  logic [15:0]          inSr;
  logic [15:0]          captured;

  assign captured    = {inSr[14:0], mdioIn};
  assign answerValid = (captured != 16'h0000) && (captured != 16'hFFFF);
  assign mdioOut     = frameSr[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
      inSr    <= '0;
    end else begin
      if (stb.load)
        frameSr <= {{PRE_LEN{1'b1}}, 2'b01, (stb.isRead ? 2'b10 : 2'b01),
                    stb.phy, stb.regAd, 2'b10, stb.wdata};
      else if (stb.shift)
        frameSr <= {frameSr[FRAME_LEN-2:0], 1'b0};
      if (stb.sample)
        inSr <= captured;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDone    <= 1'b0;
      rdData    <= '0;
      scanAddr  <= '0;
      scanMiss  <= 1'b0;
      scanValid <= 1'b0;
    end else begin
      if (stb.finish && stb.isRead && !stb.isScan) begin
        rdData <= captured;
        rdDone <= 1'b1;
      end else if (stb.load && !stb.isScan) begin
        rdDone <= 1'b0;
      end
      if (stb.finish && stb.isScan) begin
        if (answerValid) begin
          scanAddr  <= stb.phy;
          scanMiss  <= 1'b0;
          scanValid <= 1'b1;
        end else if (stb.phy == 5'd31) begin
          scanAddr  <= 5'd1;
          scanMiss  <= 1'b1;
          scanValid <= 1'b1;
        end
      end else if (stb.load && stb.isScan) begin
        scanValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  input  logic        scanStart,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [31:0] regRd,
  output logic [4:0]  scanAddr,
  output logic        scanMiss,
  output logic        scanValid
);
  mdioStrobe_t stb;
  logic        busy, answerValid, rdDone;
  logic [15:0] rdData;
  logic        unusedCmdBits;

  assign unusedCmdBits = ^cmdWrData[31:28];

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .cmdRd(cmdWrData[CMD_RD_BIT]), .cmdWr(cmdWrData[CMD_WR_BIT]),
    .cmdPhy(cmdWrData[25:21]), .cmdReg(cmdWrData[20:16]), .cmdData(cmdWrData[15:0]),
    .scanStart(scanStart), .answerValid(answerValid),
    .stb(stb), .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .answerValid(answerValid), .rdDone(rdDone), .rdData(rdData),
    .scanAddr(scanAddr), .scanMiss(scanMiss), .scanValid(scanValid)
  );

  assign regRd = {busy, 2'b00, rdDone, 12'h000, rdData};
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       busy,
  input logic       done,
  input logic [4:0] scanAddr,
  input logic       scanMiss,
  input logic       scanValid
);
  assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_mdc_high_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |=> mdc);

  assert_out_moves_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> !mdc);

  assert_done_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !done);

  assert_done_after_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy);

  assert_miss_default_R11: assert property (@(posedge clk) disable iff (!rstN)
    (scanValid && scanMiss) |-> (scanAddr == 5'd1));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(regRd[31]), .done(regRd[28]),
  .scanAddr(scanAddr), .scanMiss(scanMiss), .scanValid(scanValid)
);

// File: tb/tb_mdio_cmd_master.sv
`timescale 1ns/1ps
module tb_mdio_cmd_master;
  localparam int HALF = 10;

  logic        clk = 1'b0, rstN = 1'b0, cmdWrEn = 1'b0, scanStart = 1'b0, mdioIn = 1'b1;
  logic [31:0] cmdWrData = '0;
  logic        mdc, mdioOut, mdioOe, scanMiss, scanValid;
  logic [31:0] regRd;
  logic [4:0]  scanAddr;

  mdio_cmd_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .scanStart(scanStart), .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .regRd(regRd), .scanAddr(scanAddr), .scanMiss(scanMiss),
    .scanValid(scanValid)
  );

  always #10 clk = ~clk;

  typedef struct { bit rd; bit [4:0] phy; bit [4:0] rg; bit [15:0] wd; } exp_t;
  exp_t expQ[$];
  int nChecks = 0, nFail = 0, answerAddr = 6, viol = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  function automatic logic [15:0] respFor(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd3) begin
      if (int'(p) == answerAddr) return 16'h0141;
      return p[0] ? 16'h0000 : 16'hFFFF;
    end
    return {3'b101, p, r, 3'b011};
  endfunction

  // PHY model and frame monitor
  int onesRun = 0, preLen = 0, pos = 0;
  bit inFrame = 0, frRd = 0;
  logic [31:0] fr = '0, oeRec = '0;
  logic [15:0] resp = '0;

  function automatic logic [4:0] gather5(input int s);
    logic [4:0] v = '0;
    for (int i = 0; i < 5; i++) v = {v[3:0], fr[s+i]};
    return v;
  endfunction

  task automatic endFrame();
    exp_t e;
    logic [15:0] d = '0;
    if (expQ.size() == 0) begin
      check(0, "R7 unexpected frame", {27'b0, gather5(4)}, 32'h0);
      return;
    end
    e = expQ.pop_front();
    check(preLen == 35, "R2 preamble length", preLen, 35);
    check(fr[1] == 1'b1, "R2 start pattern", {31'b0, fr[1]}, 1);
    check({fr[2], fr[3]} == (e.rd ? 2'b10 : 2'b01), "R3 opcode", {30'b0, fr[2], fr[3]}, e.rd ? 2 : 1);
    check(gather5(4) == e.phy, "R3 phy address", {27'b0, gather5(4)}, {27'b0, e.phy});
    check(gather5(9) == e.rg, "R3 register address", {27'b0, gather5(9)}, {27'b0, e.rg});
    if (!e.rd) begin
      for (int i = 16; i < 32; i++) d = {d[14:0], fr[i]};
      check({fr[14], fr[15]} == 2'b10, "R4 turnaround", {30'b0, fr[14], fr[15]}, 2);
      check(d == e.wd, "R4 write data", {16'b0, d}, {16'b0, e.wd});
      check(&oeRec[31:1], "R4 enable held", oeRec, 32'hFFFF_FFFE);
    end else begin
      check(oeRec[30:14] == '0, "R5 pin released", oeRec, {17'b0, oeRec[13:0], 1'b0});
    end
  endtask

  always @(posedge mdc) begin
    if (!inFrame) begin
      if (mdioOe && mdioOut === 1'b1) onesRun++;
      else if (mdioOe && mdioOut === 1'b0 && onesRun >= 32) begin
        preLen = onesRun; onesRun = 0; inFrame = 1; pos = 1; fr = '0; oeRec = '0; frRd = 0;
      end else onesRun = 0;
    end else begin
      fr[pos] = mdioOut;
      oeRec[pos] = mdioOe;
      if (pos == 3) frRd = (fr[2] == 1'b1 && fr[3] == 1'b0);
      if (pos == 13) resp = respFor(gather5(4), gather5(9));
      pos++;
      if ((frRd && pos == 31) || (!frRd && pos == 32)) begin
        endFrame();
        inFrame = 0;
        onesRun = 0;
      end
    end
  end

  always @(negedge mdc)
    mdioIn = (inFrame && frRd && pos >= 15 && pos <= 30) ? resp[30-pos] : 1'b1;

  // R9 observer: data output must not move while the clock pin is high
  logic prevOut = 1'b0;
  always @(negedge clk) begin
    if (rstN && (mdioOut !== prevOut) && mdc) viol++;
    prevOut = mdioOut;
  end

  task automatic sendRaw(input logic [31:0] w);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = w;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic sendCmd(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] wd);
    exp_t e;
    e.rd = rd; e.phy = p; e.rg = r; e.wd = rd ? 16'h0 : wd;
    expQ.push_back(e);
    sendRaw({4'b0000, rd, !rd, p, r, wd});
  endtask

  task automatic pulseScan();
    @(negedge clk); scanStart = 1'b1;
    @(negedge clk); scanStart = 1'b0;
  endtask

  task automatic waitIdle();
    while (regRd[31]) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog run hung", 0, 1);
    finishRun();
  end

  initial begin
    time t0, t1, t2;
    logic [31:0] saved;
    exp_t e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRd == 32'h0, "R6 reset status", regRd, 0);
    check(!mdc && !mdioOe, "R8 idle pins", {30'b0, mdc, mdioOe}, 0);

    // write frame, clock timing, ignored command mid-frame
    sendCmd(0, 5'h12, 5'h04, 16'hA5C3);
    check(regRd[31] == 1'b1, "R6 busy after accept", regRd, 32'h8000_0000);
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check((t1 - t0) == HALF * 20, "R8 clock high time", 32'(t1 - t0), HALF * 20);
    check((t2 - t0) == HALF * 40, "R8 clock period", 32'(t2 - t0), HALF * 40);
    sendRaw({4'b0000, 1'b1, 1'b0, 5'd3, 5'd2, 16'h0});
    pulseScan();
    waitIdle();
    repeat (5) @(negedge clk);
    check(regRd == 32'h0, "R7 ignored command left status", regRd, 0);

    // read frame
    sendCmd(1, 5'd7, 5'd2, 16'h0);
    waitIdle();
    check(regRd == {4'b0001, 12'h000, respFor(5'd7, 5'd2)}, "R5 read data and done",
          regRd, {4'b0001, 12'h000, respFor(5'd7, 5'd2)});

    // both start bits: read wins (R1)
    e.rd = 1; e.phy = 5'd31; e.rg = 5'd31; e.wd = 16'h0; expQ.push_back(e);
    sendRaw({4'b0000, 2'b11, 5'd31, 5'd31, 16'h1234});
    waitIdle();
    check(regRd[15:0] == respFor(5'd31, 5'd31) && regRd[28], "R1 both bits read",
          regRd, {16'h1000, respFor(5'd31, 5'd31)});

    // neither start bit (R1)
    sendRaw({6'b000000, 5'd4, 5'd4, 16'hFFFF});
    repeat (4) @(negedge clk);
    check(!regRd[31] && regRd[28], "R1 no start bit no frame", regRd, 32'h1000_0000);

    // write clears done (R6)
    sendCmd(0, 5'd9, 5'd0, 16'h1200);
    check(regRd[31] && !regRd[28], "R6 done cleared on accept", regRd, 32'h8000_0000);
    waitIdle();

    // scan with an answering PHY at address 6
    answerAddr = 6;
    saved = regRd;
    for (int i = 0; i <= 6; i++) begin
      e.rd = 1; e.phy = 5'(i); e.rg = 5'd3; e.wd = 16'h0; expQ.push_back(e);
    end
    pulseScan();
    check(regRd[31] == 1'b1, "R10 scan busy", regRd, 32'h8000_0000);
    waitIdle();
    check(scanValid && !scanMiss && scanAddr == 5'd6, "R10 scan found",
          {25'b0, scanValid, scanMiss, scanAddr}, {25'b0, 2'b10, 5'd6});
    check(regRd == saved, "R12 scan kept status", regRd, saved);

    // scan with nobody answering
    answerAddr = 32;
    for (int i = 0; i < 32; i++) begin
      e.rd = 1; e.phy = 5'(i); e.rg = 5'd3; e.wd = 16'h0; expQ.push_back(e);
    end
    pulseScan();
    waitIdle();
    check(scanValid && scanMiss && scanAddr == 5'd1, "R11 scan miss default",
          {25'b0, scanValid, scanMiss, scanAddr}, {25'b0, 2'b11, 5'd1});
    check(regRd == saved, "R12 miss scan kept status", regRd, saved);

    check(viol == 0, "R9 output moved with clock high", viol, 0);
    check(expQ.size() == 0, "R7 all expected frames seen", expQ.size(), 0);
    finishRun();
  end
endmodule